// File: doc/BRIEF.md
# Watchdog Timer with Guarded Control

The block counts clock ticks in a counter that is free to run while enabled. Software must clear it well before it reaches its top value. If software stops doing so, the counter overflows and the block drives a reset request to the system reset logic. The request lasts a fixed number of cycles. After it, counting starts again from zero.

Software reaches the block through a small register port of four 8-bit locations. Any write to the kick location clears the counter. A write to the control location, which holds the enable bit and the tick divider, is honoured only when a two-write key sequence comes directly before it. Stray writes from runaway code therefore cannot stop the watchdog. A sticky cause flag records that a watchdog reset took place. It stays set through the system reset that the watchdog itself causes, and is lost only on power-on reset or when software writes one to it.

The register port has no valid/ready handshake. A write is taken in any cycle where `bus_we` is high. Reads are combinational from `bus_addr`. No data stream passes through the block, so there is no back-pressure.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset `wdt_rst` is low, the control location (address 2) reads 01h (enable = bit 0 = 1, divider select = bits 2:1 = 0), the status location (address 3) reads 00h, and the key location (address 1) reads 00h.
- R2: With divider select 0, the last kick written at clock edge K makes `wdt_rst` go high right after edge K + 2^CNT_W. One cycle earlier it is still low.
- R3: The reset request stays high for exactly PULSE_LEN (4) cycles. Counting then starts again from zero, so without a kick the next request comes PULSE_LEN + 2^CNT_W·D cycles after the previous one rose.
- R4: A write of any value to address 0 (kick) clears the counter. Kicks spaced less than 2^CNT_W·D cycles apart keep `wdt_rst` low.
- R5: A kick at the same edge as an overflow wins. No request is issued, and the counter starts again from zero at that edge.
- R6: Status bit 0 is set by every overflow. A system reset (`sys_rst_n` low) leaves it set. Writing 0 to it has no effect. Writing 1 to address 3 bit 0 clears it. Power-on reset clears it.
- R7: A write to address 2 that does not come directly after the key sequence leaves the control value unchanged.
- R8: A write of 55h to address 1, followed by a write of AAh to address 1 as the next bus write, opens the control location for exactly the next bus write. A second control write after that is ignored.
- R9: Any other value written to address 1, or a write to another address between the two key writes, cancels the sequence.
- R10: Divider select values 0, 1, 2 and 3 make the counter advance once every 1, 4, 16 or 64 clocks. A kick also restarts the divider, so the request follows the kick by 2^CNT_W·D cycles.
- R11: With the enable bit cleared, the counter does not advance and no request is issued.
- R12: A system reset clears the counter, the divider and any key progress, and restores the control value 01h. It leaves the cause flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| sys_rst_n | input | 1 | System reset, synchronous, active low; keeps the cause flag |
| bus_we | input | 1 | Register write strobe, taken in any cycle it is high |
| bus_addr | input | 2 | Register select: 0 kick, 1 key, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wdt_rst | output | 1 | Reset request pulse to the system reset logic |

## Verification
The assertions check on every cycle that:
- a request always lasts PULSE_LEN cycles and leaves the counter at zero;
- a kick taken while no request is running never lets one start;
- the control value cannot change unless the key window is open, and the window closes after one write;
- the cause flag stays set until it is cleared and is set whenever a request rises.

The bench scenarios are needed to show the exact edge at which a request rises after a kick under each divider setting. They also show that the next request follows the end of the previous one. Two more things rest on the scenarios alone: the key sequences that should be cancelled are indeed cancelled, and the flag survives a system reset.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  typedef enum logic [1:0] {
    RG_KICK = 2'd0,
    RG_KEY  = 2'd1,
    RG_CTRL = 2'd2,
    RG_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  typedef struct packed {
    logic [1:0] psel;
    logic       en;
  } ctrl_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam ctrl_t      CTRL_RESET = '{psel: 2'd0, en: 1'b1};
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              clr,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int PRE_W = 2 * ((1 << PSEL_W) - 1);

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   pre <= '0;
    else if (clr) pre <= '0;
    else if (run) pre <= pre + 1'b1;
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < 2 * int'(psel));
  end

  assign tick = run && ((pre & mask) == mask);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic tick,
  input  logic kick,
  output logic busy,
  output logic overflow,
  output logic rst_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam int HW = PW + 1;

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pc;

  assign busy     = (pc != '0);
  assign rst_o    = busy;
  assign overflow = tick && (cnt == '1) && !kick && !busy && sys_rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                    cnt <= '0;
    else if (!sys_rst_n || kick || busy || overflow) cnt <= '0;
    else if (tick)                                 cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         pc <= '0;
    else if (overflow)  pc <= PW'(PULSE_LEN);
    else if (pc != '0)  pc <= pc - 1'b1;
  end

  // checker: length of the current high phase
  logic [HW-1:0] hi_len;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     hi_len <= '0;
    else if (rst_o) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> (hi_len == HW'(PULSE_LEN))); // R3
  AST_ZERO_AFTER_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    rst_o |=> (cnt == '0)); // R3
  AST_KICK_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (kick && !rst_o) |=> !rst_o); // R5
endmodule

// File: rtl/wdt_lock.sv
module wdt_lock
  import wdt_guard_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     sys_rst_n,
  input  logic     we,
  input  reg_sel_e sel,
  input  logic [7:0] wdata,
  output ctrl_t    ctrl,
  output logic     ctrl_load
);
  lock_e state;

  assign ctrl_load = we && (sel == RG_CTRL) && (state == LK_OPEN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          state <= LK_SHUT;
    else if (!sys_rst_n) state <= LK_SHUT;
    else if (we) begin
      if (sel == RG_KEY) begin
        if (wdata == KEY_FIRST)                             state <= LK_HALF;
        else if (state == LK_HALF && wdata == KEY_SECOND)   state <= LK_OPEN;
        else                                                state <= LK_SHUT;
      end else begin
        state <= LK_SHUT;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          ctrl <= CTRL_RESET;
    else if (!sys_rst_n) ctrl <= CTRL_RESET;
    else if (ctrl_load)  ctrl <= ctrl_t'(wdata[2:0]);
  end

  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!por_n)
    (we && sel == RG_CTRL && state != LK_OPEN && sys_rst_n) |=> $stable(ctrl)); // R7
  AST_ONE_SHOT_WINDOW: assert property (@(posedge clk) disable iff (!por_n)
    (state == LK_OPEN && we) |=> (state != LK_OPEN)); // R8
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst
);
  reg_sel_e sel;
  ctrl_t    ctrl;
  logic     ctrl_load;
  logic     kick;
  logic     tick;
  logic     busy;
  logic     overflow;
  logic     flag;
  logic     flag_clr;

  assign sel      = reg_sel_e'(bus_addr);
  assign kick     = bus_we && (sel == RG_KICK);
  assign flag_clr = bus_we && (sel == RG_STAT) && bus_wdata[0];

  wdt_lock u_lock (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .we(bus_we), .sel(sel), .wdata(bus_wdata),
    .ctrl(ctrl), .ctrl_load(ctrl_load)
  );

  wdt_prescale #(.PSEL_W(2)) u_pre (
    .clk(clk), .por_n(por_n),
    .clr(kick || busy || ctrl_load || !sys_rst_n),
    .run(ctrl.en), .psel(ctrl.psel), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .tick(tick), .kick(kick),
    .busy(busy), .overflow(overflow), .rst_o(wdt_rst)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag <= 1'b0;
    else if (overflow) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_comb begin
    case (sel)
      RG_CTRL: bus_rdata = {5'b0, ctrl};
      RG_STAT: bus_rdata = {7'b0, flag};
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (flag && !flag_clr) |=> flag); // R6
  AST_FLAG_ON_RESET: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_rst) |-> flag); // R6
endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
  localparam int W = 10;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sys_rst_n = 1'b1;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic wdt_rst;

  always #2.5 clk = ~clk;

  wdt_guard #(.CNT_W(W), .PULSE_LEN(4)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rises = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge wdt_rst) rises++;

  typedef struct { int at; logic val; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cyc %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares the reset output against scheduled expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      if (e.at < cyc) chk({e.tag, " missed"}, 32'(e.at), 32'(cyc));
      else            chk(e.tag, {31'b0, wdt_rst}, {31'b0, e.val});
    end
  end

  task automatic push(input int at, input logic v, input string tag);
    exp_t x;
    x.at = at; x.val = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic expect_pulse(input int k, input int d, input string tag);
    push(k + N*d - 1, 1'b0, tag);
    push(k + N*d,     1'b1, tag);
    push(k + N*d + 3, 1'b1, {tag, " R3 hold"});
    push(k + N*d + 4, 1'b0, {tag, " R3 end"});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain;
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic unlock;
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 timeout act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    int k, r0;
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R1 ctrl during por", 32'(v), 32'h01);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 rst low", {31'b0, wdt_rst}, 0);
    rd(2'd2, v); chk("R1 ctrl", 32'(v), 32'h01);
    rd(2'd3, v); chk("R1 status", 32'(v), 32'h00);
    rd(2'd1, v); chk("R1 key", 32'(v), 32'h00);

    // R2 / R3: overflow at divide-by-1, then free restart
    wr(2'd0, 8'h00); k = cyc;
    expect_pulse(k, 1, "R2 div1");
    push(k + 2*N + 4 - 1, 1'b0, "R3 restart early");
    push(k + 2*N + 4,     1'b1, "R3 restart");
    wait_until(k + N + 5);
    rd(2'd3, v); chk("R6 flag set", 32'(v), 32'h01);
    drain();
    wait_until(k + 2*N + 10);

    // R6 / R12: flag survives system reset, software clear
    sys_rst_n = 1'b0; repeat (2) @(negedge clk); sys_rst_n = 1'b1;
    rd(2'd3, v); chk("R6 flag after sys reset", 32'(v), 32'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R6 write 0 no effect", 32'(v), 32'h01);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R6 write 1 clears", 32'(v), 32'h00);

    // R4: periodic kicks hold off the request
    r0 = rises;
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, 8'h5A);
      repeat (N - 10) @(negedge clk);
    end
    chk("R4 no request with kicks", 32'(rises), 32'(r0));

    // R5: kick coinciding with overflow wins
    wr(2'd0, 8'h00); k = cyc;
    wait_until(k + N - 1);
    r0 = rises;
    wr(2'd0, 8'h00);
    chk("R5 kick edge", 32'(cyc), 32'(k + N));
    k = cyc;
    wait_until(k + 3);
    chk("R5 no request", 32'(rises), 32'(r0));
    expect_pulse(k, 1, "R5 restart");
    drain();

    // R7: locked write ignored
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R7 locked ctrl", 32'(v), 32'h01);

    // R9: cancelled sequences
    wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 wrong key", 32'(v), 32'h01);
    wr(2'd1, 8'h55); wr(2'd0, 8'h00); wr(2'd1, 8'hAA); wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 intervening write", 32'(v), 32'h01);
    wr(2'd1, 8'hAA); wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 second key alone", 32'(v), 32'h01);

    // R8: one-shot window
    unlock(); wr(2'd2, 8'h03);
    rd(2'd2, v); chk("R8 unlocked write", 32'(v), 32'h03);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R8 window closed", 32'(v), 32'h03);

    // R10: divider settings
    wr(2'd0, 8'h00); k = cyc;
    expect_pulse(k, 4, "R10 div4");
    drain();
    unlock(); wr(2'd2, 8'h05);
    wr(2'd0, 8'h00); k = cyc;
    expect_pulse(k, 16, "R10 div16");
    drain();
    unlock(); wr(2'd2, 8'h07);
    wr(2'd0, 8'h00); k = cyc;
    expect_pulse(k, 64, "R10 div64");
    drain();

    // R11: disabled counter
    unlock(); wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R11 ctrl disabled", 32'(v), 32'h00);
    r0 = rises;
    wr(2'd0, 8'h00);
    repeat (3*N) @(negedge clk);
    chk("R11 no request", 32'(rises), 32'(r0));
    chk("R11 rst low", {31'b0, wdt_rst}, 0);

    // R12: system reset restores control and cancels unlock
    unlock(); wr(2'd2, 8'h07);
    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
    rd(2'd2, v); chk("R12 ctrl default", 32'(v), 32'h01);
    unlock();
    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R12 unlock cancelled", 32'(v), 32'h01);
    rd(2'd3, v); chk("R12 flag kept", 32'(v), 32'h01);
    wr(2'd0, 8'h00); k = cyc;
    expect_pulse(k, 1, "R12 counts after sys reset");
    drain();

    // R6: power-on reset clears flag
    por_n = 1'b0; #1;
    rd(2'd3, v); chk("R6 por clears flag", 32'(v), 32'h00);
    @(negedge clk); por_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule